// File: doc/BRIEF.md
# Serial Converter Frame Transmitter

This block is the host-side master for a dual 8-bit converter that takes one 16-bit word per update over a three-wire serial port. A parallel word and a one-cycle start pulse go in. The block pulls the frame-select line low. It then produces a serial clock from the system clock through a divider that software sets, and shifts the word out most significant bit first: the control byte first, then the data byte. The data line changes only while the serial clock is low, so it is stable at the receiver's rising-edge sample.

After the last bit the select line is held low for one more half period and then released. The block then keeps the line high for a programmable number of serial clock periods before it reports completion. A split mode sends the frame as two 8-bit bursts separated by a programmable gap. The select line stays low across the gap. For byte sources that emit the least significant bit first, an option mirrors each byte before it is sent.

Top module: `dac_frame_tx`

## Requirements
- R1: After reset, `sync_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: A frame carries exactly 16 bits. `word_in[15]` is presented on `din` at the first rising `sclk` edge and `word_in[0]` at the sixteenth. `din` changes only while `sclk` is low.
- R3: With divider value N, each `sclk` high phase and each ordinary low phase lasts N+1 system clocks, giving a period of 2·(N+1). `sclk` is 0 whenever `sync_n` is 1.
- R4: `sync_n` falls N+1 system clocks before the first rising `sclk` edge. It rises N+1 system clocks after the falling edge that follows the sixteenth rising edge, and never before that sixteenth edge.
- R5: With `split_en`=1 and gap value G, the low phase after the eighth bit is extended by 2·(N+1)·G system clocks with `sclk` low and `sync_n` low. With G=0, or with `split_en`=0, no gap is inserted.
- R6: After `sync_n` rises, it stays high for 2·(N+1)·IDLE_PERIODS system clocks. In the next cycle `done` is 1 for exactly one cycle and `busy` is 0.
- R7: With `lsb_first`=1, each byte is mirrored: bits [15:8] are sent as `word_in[8]` first through `word_in[15]` last, and bits [7:0] as `word_in[0]` first through `word_in[7]` last.
- R8: A start pulse while `busy` is 1 is ignored. `word_in`, `div_n`, `split_en`, `gap_n` and `lsb_first` are sampled only in the cycle a start is accepted, so later changes do not affect the frame in flight.
- R9: `busy` is 1 from the cycle after an accepted start until the cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to send `word_in` |
| word_in | input | 16 | Control byte in [15:8], data byte in [7:0] |
| div_n | input | DIV_W | Divider value N; serial period is 2·(N+1) system clocks |
| split_en | input | 1 | Send as two byte bursts with a gap between them |
| gap_n | input | GAP_W | Gap length in serial clock periods for split mode |
| lsb_first | input | 1 | Mirror each byte before sending |
| sclk | output | 1 | Serial clock, idles low |
| din | output | 1 | Serial data |
| sync_n | output | 1 | Active-low frame select |
| busy | output | 1 | Frame or post-frame idle in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check a set of rules on every cycle. Data never moves while the clock is high, and the clock is low whenever select is released. Select may rise only after sixteen rising edges have been counted. No high phase outlasts the latched divider, that divider is frozen while busy, and done is a single cycle that never overlaps busy. The exact cycle placement can only be shown by the bench's scenarios, which compare whole-frame traces against traces built arithmetically. Those scenarios cover lead time, tail hold, gap length, post-frame idle, the decoded bit order with and without mirroring, and the rejection of a start and new settings arriving mid-frame.

// File: rtl/dacf_pkg.sv
package dacf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_GAP,
      ST_TAIL,
      ST_REST
   } dacf_state_t;

endpackage

// File: rtl/dacf_byte_order.sv
module dacf_byte_order #(
   parameter int BYTE_W      = 8,
   parameter int N_BYTES     = 2,
   parameter bit ALLOW_MIRROR = 1'b1,
   localparam int WORD_W     = BYTE_W * N_BYTES
) (
   input  logic              mirror,
   input  logic [WORD_W-1:0] raw,
   output logic [WORD_W-1:0] ordered
);

   generate
      if (BYTE_W < 1 || N_BYTES < 1) begin : g_bad
         $error("dacf_byte_order: BYTE_W and N_BYTES must be positive");
      end
      if (ALLOW_MIRROR) begin : g_mirror
         for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
            for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
               assign ordered[k*BYTE_W + i] =
                  mirror ? raw[k*BYTE_W + BYTE_W - 1 - i] : raw[k*BYTE_W + i];
            end
         end
      end else begin : g_pass
         assign ordered = raw;
         logic unused_mirror;
         assign unused_mirror = mirror;
      end
   endgenerate

endmodule

// File: rtl/dacf_phase_timer.sv
module dacf_phase_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   generate
      if (CW < 1) begin : g_bad
         $error("dacf_phase_timer: CW must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/dacf_shifter.sv
module dacf_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_val,
   input  logic              advance,
   output logic              msb
);

   logic [WORD_W-1:0] sh_q;

   generate
      if (WORD_W < 2) begin : g_bad
         $error("dacf_shifter: WORD_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         sh_q <= '0;
      else if (load)
         sh_q <= load_val;
      else if (advance)
         sh_q <= {sh_q[WORD_W-2:0], 1'b0};
   end

   assign msb = sh_q[WORD_W-1];

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx #(
   parameter int DIV_W        = 8,
   parameter int GAP_W        = 4,
   parameter int IDLE_PERIODS = 1,
   parameter int BYTE_W       = 8,
   parameter bit ALLOW_MIRROR = 1'b1,
   localparam int WORD_W      = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word_in,
   input  logic [DIV_W-1:0]  div_n,
   input  logic              split_en,
   input  logic [GAP_W-1:0]  gap_n,
   input  logic              lsb_first,
   output logic              sclk,
   output logic              din,
   output logic              sync_n,
   output logic              busy,
   output logic              done
);
   import dacf_pkg::*;

   localparam int BC_W   = $clog2(WORD_W + 1);
   localparam int IW     = $clog2(2 * IDLE_PERIODS + 1);
   localparam int HC_W   = (GAP_W + 1 > IW) ? GAP_W + 1 : IW;
   localparam logic [BC_W-1:0] LAST_BIT  = BC_W'(WORD_W - 1);
   localparam logic [BC_W-1:0] SPLIT_BIT = BC_W'(BYTE_W);
   localparam logic [HC_W-1:0] REST_HALVES = HC_W'(2 * IDLE_PERIODS);
   localparam logic [HC_W-1:0] ONE_HALF    = HC_W'(1);

   generate
      if (DIV_W < 1 || GAP_W < 1) begin : g_bad_w
         $error("dac_frame_tx: DIV_W and GAP_W must be positive");
      end
      if (IDLE_PERIODS < 1) begin : g_bad_idle
         $error("dac_frame_tx: IDLE_PERIODS must be at least 1");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("dac_frame_tx: BYTE_W must be positive");
      end
   endgenerate

   dacf_state_t        state_q, state_d;
   logic [DIV_W-1:0]   div_q;
   logic [GAP_W-1:0]   gap_q;
   logic               split_q;
   logic [BC_W-1:0]    bitc_q;
   logic [HC_W-1:0]    halves_q;
   logic               sclk_q, sync_q, done_q;
   logic               accept, tz, t_load, sh_adv;
   logic [DIV_W-1:0]   t_val;
   logic [WORD_W-1:0]  ordered;
   logic               gap_needed;

   assign accept     = (state_q == ST_IDLE) && start;
   assign gap_needed = split_q && (bitc_q == SPLIT_BIT) && (gap_q != '0);

   dacf_byte_order #(
      .BYTE_W       (BYTE_W),
      .N_BYTES      (2),
      .ALLOW_MIRROR (ALLOW_MIRROR)
   ) u_order (
      .mirror  (lsb_first),
      .raw     (word_in),
      .ordered (ordered)
   );

   assign t_load = accept || ((state_q != ST_IDLE) && tz);
   assign t_val  = (state_q == ST_IDLE) ? div_n : div_q;

   dacf_phase_timer #(.CW(DIV_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (tz)
   );

   assign sh_adv = (state_q == ST_HIGH) && tz && (bitc_q != LAST_BIT);

   dacf_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (ordered),
      .advance  (sh_adv),
      .msb      (din)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start) state_d = ST_LEAD;
         ST_LEAD: if (tz) state_d = ST_HIGH;
         ST_HIGH: if (tz) state_d = (bitc_q == LAST_BIT) ? ST_TAIL : ST_LOW;
         ST_LOW:  if (tz) state_d = gap_needed ? ST_GAP : ST_HIGH;
         ST_GAP:  if (tz && halves_q == ONE_HALF) state_d = ST_HIGH;
         ST_TAIL: if (tz) state_d = ST_REST;
         ST_REST: if (tz && halves_q == ONE_HALF) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         div_q    <= '0;
         gap_q    <= '0;
         split_q  <= 1'b0;
         bitc_q   <= '0;
         halves_q <= '0;
         sclk_q   <= 1'b0;
         sync_q   <= 1'b1;
         done_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         sclk_q  <= (state_d == ST_HIGH);
         sync_q  <= (state_d == ST_IDLE) || (state_d == ST_REST);
         done_q  <= (state_q == ST_REST) && (state_d == ST_IDLE);
         if (accept) begin
            div_q   <= div_n;
            gap_q   <= gap_n;
            split_q <= split_en;
            bitc_q  <= '0;
         end
         if (state_q == ST_HIGH && tz)
            bitc_q <= bitc_q + 1'b1;
         if (state_q == ST_LOW && tz && gap_needed)
            halves_q <= HC_W'({gap_q, 1'b0});
         else if (state_q == ST_TAIL && tz)
            halves_q <= REST_HALVES;
         else if ((state_q == ST_GAP || state_q == ST_REST) && tz)
            halves_q <= halves_q - 1'b1;
      end
   end

   assign sclk   = sclk_q;
   assign sync_n = sync_q;
   assign busy   = (state_q != ST_IDLE);
   assign done   = done_q;

   // ---------------- embedded checks ----------------
   logic [BC_W:0]  edges_q;
   logic [DIV_W:0] hi_run_q;
   logic           sclk_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edges_q     <= '0;
         hi_run_q    <= '0;
         sclk_prev_q <= 1'b0;
      end else begin
         sclk_prev_q <= sclk_q;
         hi_run_q    <= sclk_q ? hi_run_q + 1'b1 : '0;
         if (sync_q && !$rose(sync_q))
            edges_q <= '0;
         else if (sclk_q && !sclk_prev_q)
            edges_q <= edges_q + 1'b1;
      end
   end

   p_din_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_q |-> $stable(din));

   p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |-> !sclk_q);

   p_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_q |-> (hi_run_q <= {1'b0, div_q}));

   p_sync_after_16_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_q) |-> (edges_q == (BC_W+1)'(WORD_W)));

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   p_div_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(div_q));

   p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy);

endmodule

// File: tb/dac_frame_tx_test.sv
`timescale 1ns/1ps
module dac_frame_tx_test;

   localparam int DIV_W = 2;
   localparam int GAP_W = 2;
   localparam int IDLE_P = 2;
   localparam int MAXT  = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [15:0] word_in = '0;
   logic [DIV_W-1:0] div_n = '0;
   logic split_en = 1'b0;
   logic [GAP_W-1:0] gap_n = '0;
   logic lsb_first = 1'b0;
   logic sclk, din, sync_n, busy, done;

   int errors = 0;
   int checks = 0;

   bit r_sclk [MAXT];
   bit r_sync [MAXT];
   bit r_din  [MAXT];
   bit r_busy [MAXT];
   bit r_done [MAXT];
   bit e_sclk [MAXT];
   bit e_sync [MAXT];
   bit e_busy [MAXT];
   bit e_done [MAXT];
   int rlen, elen;

   always #2.5 clk = ~clk;

   dac_frame_tx #(
      .DIV_W(DIV_W), .GAP_W(GAP_W), .IDLE_PERIODS(IDLE_P)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
      .div_n(div_n), .split_en(split_en), .gap_n(gap_n),
      .lsb_first(lsb_first), .sclk(sclk), .din(din), .sync_n(sync_n),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mirror_bytes(input logic [15:0] w);
      logic [15:0] r;
      for (int i = 0; i < 8; i++) begin
         r[8+i] = w[15-i];
         r[i]   = w[7-i];
      end
      return r;
   endfunction

   task automatic put(input bit s, input bit y, input bit b, input bit d);
      if (elen < MAXT) begin
         e_sclk[elen] = s; e_sync[elen] = y; e_busy[elen] = b; e_done[elen] = d;
      end
      elen++;
   endtask

   // expected trace built from R3..R6, R9
   task automatic build_expected(input int n, input bit sp, input int g);
      int h = n + 1;
      elen = 0;
      for (int c = 0; c < h; c++) put(0, 0, 1, 0);
      for (int b = 0; b < 16; b++) begin
         for (int c = 0; c < h; c++) put(1, 0, 1, 0);
         for (int c = 0; c < h; c++) put(0, 0, 1, 0);
         if (b == 7 && sp)
            for (int c = 0; c < 2*h*g; c++) put(0, 0, 1, 0);
      end
      for (int c = 0; c < 2*h*IDLE_P; c++) put(0, 1, 1, 0);
      put(0, 1, 0, 1);
   endtask

   task automatic record_frame();
      rlen = 0;
      forever begin
         if (rlen < MAXT) begin
            r_sclk[rlen] = sclk; r_sync[rlen] = sync_n; r_din[rlen] = din;
            r_busy[rlen] = busy; r_done[rlen] = done;
         end
         rlen++;
         if (done || rlen >= MAXT) break;
         @(negedge clk);
      end
      if (rlen >= MAXT) check(0, "R6", "watchdog: no done", rlen, 0);
   endtask

   task automatic compare(input logic [15:0] exp_word, input string tag);
      int bad_s = -1, bad_y = -1, bad_b = -1;
      logic [15:0] got = '0;
      int nbits = 0;
      bit prev = 0;
      check(rlen == elen, "R6", {tag, " frame length"}, rlen, elen);
      for (int i = 0; i < rlen && i < elen && i < MAXT; i++) begin
         if (r_sclk[i] != e_sclk[i] && bad_s < 0) bad_s = i;
         if (r_sync[i] != e_sync[i] && bad_y < 0) bad_y = i;
         if ((r_busy[i] != e_busy[i] || r_done[i] != e_done[i]) && bad_b < 0) bad_b = i;
      end
      check(bad_s < 0, "R3/R5", {tag, " sclk trace first bad cycle"}, bad_s, -1);
      check(bad_y < 0, "R4/R6", {tag, " sync trace first bad cycle"}, bad_y, -1);
      check(bad_b < 0, "R9", {tag, " busy/done trace first bad cycle"}, bad_b, -1);
      for (int i = 0; i < rlen && i < MAXT; i++) begin
         if (r_sclk[i] && !prev && !r_sync[i]) begin
            got = {got[14:0], r_din[i]};
            nbits++;
         end
         prev = r_sclk[i];
      end
      check(nbits == 16, "R2", {tag, " rising edge count"}, nbits, 16);
      check(got == exp_word, "R2/R7", {tag, " received word"}, got, exp_word);
   endtask

   task automatic launch(input logic [15:0] w, input int n, input bit sp,
                         input int g, input bit lf);
      @(negedge clk);
      word_in = w; div_n = DIV_W'(n); split_en = sp; gap_n = GAP_W'(g);
      lsb_first = lf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      check(sync_n == 1 && sclk == 0 && busy == 0 && done == 0, "R1",
            "reset outputs", {sync_n, sclk, busy, done}, 4'b1000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(sync_n == 1 && sclk == 0 && busy == 0, "R1",
            "idle after reset", {sync_n, sclk, busy}, 3'b100);

      // sweep: divider, split/gap, bit order (R2..R7, R9)
      for (int n = 0; n < 4; n++) begin
         for (int m = 0; m < 5; m++) begin
            for (int lf = 0; lf < 2; lf++) begin
               bit sp = (m != 0);
               int g  = sp ? m - 1 : 3;
               logic [15:0] w = 16'hA5C3 ^ 16'((n * 16'h1357) + (m * 16'h0F21) + lf * 16'h8001);
               logic [15:0] exp_w = lf ? mirror_bytes(w) : w;
               launch(w, n, sp, g, lf[0]);
               record_frame();
               build_expected(n, sp, g);
               compare(exp_w, $sformatf("n=%0d split=%0d gap=%0d lsb=%0d", n, sp, g, lf));
               repeat (3) @(negedge clk);
            end
         end
      end

      // R8: start and new settings during a frame are ignored
      launch(16'h3C96, 1, 1'b0, 0, 1'b0);
      fork
         record_frame();
         begin
            repeat (8) @(negedge clk);
            word_in = 16'hFFFF; div_n = DIV_W'(3); split_en = 1'b1;
            gap_n = GAP_W'(2); lsb_first = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      join
      build_expected(1, 1'b0, 0);
      compare(16'h3C96, "R8 restart ignored");
      begin
         int lows = 0;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!sync_n || busy) lows++;
         end
         check(lows == 0, "R8", "no second frame after ignored start", lows, 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule